// File: doc/BRIEF.md
# Boot Lockup Watchdog Monitor

This block oversees the window between the release of processor reset and the processor's first instruction fetch. When the processor leaves reset, a countdown timer starts from a programmable load value and is decremented on each timer tick. If the first fetch strobe never arrives and the timer runs out twice in a row, the processor is taken to be hung. The block then drives a platform bus reset pulse of fixed length, and afterwards it arms itself again for the next boot attempt.

The data returned with the first fetch is also inspected. An all-ones byte means the firmware device has never been programmed, and a status flag records it. Every detected condition sets a sticky status bit that software clears by writing ones. Each condition also raises a one-cycle pulse on one of five event lines, chosen by a selector input.

All outputs are registered. The block has a synchronous, active-high reset.

Top module: `boot_watch`

## Requirements
- R1: While `rst` is high, at the next clock edge `bus_rst` goes to 0, `status` goes to 3'b000 and `evt_out` goes to 5'b00000.
- R2: When the block is idle and `cpu_rst` is low, it arms at the next edge and loads the countdown with the current load value L. Each `tick` decrements a non-zero count. A `tick` that finds the count at zero is an expiry, so the first expiry falls on the (L+1)-th tick after arming.
- R3: The first expiry with no fetch sets `status[0]` (first timeout) and reloads the countdown with L. It does not assert `bus_rst`.
- R4: A second consecutive expiry sets `status[1]` (lockup) and raises `bus_rst` at the same clock edge. `bus_rst` stays high for exactly 16 cycles.
- R5: A `fetch_vld` while armed ends the wait, and later ticks set no timeout bit. A fetch in the same cycle as an expiry takes priority, so that expiry is discarded.
- R6: If the data of the first fetch after arming equals 8'hFF (all ones), `status[2]` (blank firmware) is set. Any other value leaves it clear, and fetches after the first are not inspected.
- R7: `status` is sticky. A cycle with `clr_we` high clears each bit whose `clr_mask` bit is 1. A set in the same cycle wins over the clear.
- R8: Every cycle in which any status bit is set produces a one-cycle pulse on `evt_out[evt_sel]`, with bit 0 SMI, 1 SCI, 2 SERR, 3 NMI and 4 management interrupt. Selector codes 5 to 7 give no pulse.
- R9: `reload_we` stores `reload_val` as the new load value. A running count is not changed; the new value is used at the next arming or at the reload after the first expiry.
- R10: Raising `cpu_rst` while armed abandons the wait and forgets any first expiry, and the block re-arms when `cpu_rst` is low again. After the bus reset pulse ends the block returns to idle and re-arms if `cpu_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rst | input | 1 | Processor reset, high while the processor is held in reset |
| tick | input | 1 | Timer tick enable |
| fetch_vld | input | 1 | First-fetch strobe |
| fetch_data | input | 8 | Data returned with the fetch |
| reload_we | input | 1 | Load value write strobe |
| reload_val | input | 16 | New load value |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask for `status` |
| evt_sel | input | 3 | Event line selector |
| bus_rst | output | 1 | Platform bus reset pulse |
| status | output | 3 | Sticky status: [0] first timeout, [1] lockup, [2] blank firmware |
| evt_out | output | 5 | One-hot event pulses |

## Verification
Every result shows up one edge after the input that causes it. An expiry appears in `status` and `evt_out` on the edge of the zero-count tick; for L=3 and a tick in every cycle, that is the 5th edge after release for the first expiry and the 9th edge for the bus reset. A fetch or a clear shows up on the edge that samples it. The bench drives inputs and compares outputs on the falling edge against a behavioural model that steps once per rising edge. Directed checks then wait a counted number of falling edges, derived from these latencies, before they sample.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int NUM_STS = 3;
  localparam int NUM_EVT = 5;
  localparam int SEL_W   = $clog2(NUM_EVT);

  localparam int STS_FIRST = 0;
  localparam int STS_LOCK  = 1;
  localparam int STS_BLANK = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSRST = 2'd2,
    ST_DONE  = 2'd3
  } bw_state_e;
endpackage

// File: rtl/bw_timer.sv
module bw_timer #(
  parameter int CNT_W     = 16,
  parameter int INIT_LOAD = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             en,
  input  logic             tick,
  input  logic             load,
  output logic             expire
);
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= CNT_W'(INIT_LOAD);
    end else if (reload_we) begin
      load_q <= reload_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_q;
    end else if (en && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = en && tick && (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_q))); // R2

  AST_TMR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/bw_fsm.sv
module bw_fsm
  import bw_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_rst,
  input  logic               fetch_vld,
  input  logic [DATA_W-1:0]  fetch_data,
  input  logic               expire,
  output logic               tmr_en,
  output logic               tmr_load,
  output logic [NUM_STS-1:0] set_vec,
  output logic               bus_rst
);
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [DATA_W-1:0] BLANK_VAL = {DATA_W{1'b1}};

  bw_state_e state_q, state_d;
  logic exp1_q, exp1_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  always_comb begin
    state_d  = state_q;
    exp1_d   = exp1_q;
    hold_d   = hold_q;
    tmr_load = 1'b0;
    set_vec  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (!cpu_rst) begin
          state_d  = ST_ARMED;
          exp1_d   = 1'b0;
          tmr_load = 1'b1;
        end
      end
      ST_ARMED: begin
        if (cpu_rst) begin
          state_d = ST_IDLE;
          exp1_d  = 1'b0;
        end else if (fetch_vld) begin
          state_d = ST_DONE;
          if (fetch_data == BLANK_VAL) begin
            set_vec[STS_BLANK] = 1'b1;
          end
        end else if (expire) begin
          if (!exp1_q) begin
            exp1_d   = 1'b1;
            tmr_load = 1'b1;
            set_vec[STS_FIRST] = 1'b1;
          end else begin
            state_d = ST_BUSRST;
            hold_d  = '0;
            set_vec[STS_LOCK] = 1'b1;
          end
        end
      end
      ST_BUSRST: begin
        if (hold_q == HOLD_W'(HOLD_CYC - 1)) begin
          state_d = ST_IDLE;
          exp1_d  = 1'b0;
        end else begin
          hold_d = hold_q + HOLD_W'(1);
        end
      end
      ST_DONE: begin
        if (cpu_rst) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      exp1_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      exp1_q  <= exp1_d;
      hold_q  <= hold_d;
    end
  end

  assign tmr_en  = (state_q == ST_ARMED);
  assign bus_rst = (state_q == ST_BUSRST);

  AST_DONE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> (set_vec[STS_FIRST] == 1'b0 && set_vec[STS_LOCK] == 1'b0)); // R5

  AST_CANCEL_ON_CPU_RST: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && cpu_rst) |=> (state_q == ST_IDLE && !exp1_q)); // R10

  AST_LOCK_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst) |-> $past(exp1_q)); // R4
endmodule

// File: rtl/bw_status.sv
module bw_status
  import bw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STS-1:0] set_vec,
  input  logic               clr_we,
  input  logic [NUM_STS-1:0] clr_mask,
  output logic [NUM_STS-1:0] status
);
  logic [NUM_STS-1:0] sts_q;

  for (genvar i = 0; i < NUM_STS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q[i] <= 1'b0;
      end else if (set_vec[i]) begin
        sts_q[i] <= 1'b1;
      end else if (clr_we && clr_mask[i]) begin
        sts_q[i] <= 1'b0;
      end
    end
  end

  assign status = sts_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R7
endmodule

// File: rtl/bw_evt.sv
module bw_evt
  import bw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] evt_sel,
  output logic [NUM_EVT-1:0] evt_out
);
  logic [NUM_EVT-1:0] evt_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q[i] <= 1'b0;
      end else begin
        evt_q[i] <= fire && (evt_sel == SEL_W'(i));
      end
    end
  end

  assign evt_out = evt_q;

  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_out)); // R8
endmodule

// File: rtl/boot_watch.sv
module boot_watch
  import bw_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int INIT_LOAD = 1000,
  parameter int DATA_W    = 8,
  parameter int HOLD_CYC  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_rst,
  input  logic               tick,
  input  logic               fetch_vld,
  input  logic [DATA_W-1:0]  fetch_data,
  input  logic               reload_we,
  input  logic [CNT_W-1:0]   reload_val,
  input  logic               clr_we,
  input  logic [NUM_STS-1:0] clr_mask,
  input  logic [SEL_W-1:0]   evt_sel,
  output logic               bus_rst,
  output logic [NUM_STS-1:0] status,
  output logic [NUM_EVT-1:0] evt_out
);
  localparam int RUN_W = $clog2(HOLD_CYC + 2);

  logic tmr_en, tmr_load, expire;
  logic [NUM_STS-1:0] set_vec;

  bw_timer #(.CNT_W(CNT_W), .INIT_LOAD(INIT_LOAD)) u_timer (
    .clk(clk), .rst(rst), .reload_we(reload_we), .reload_val(reload_val),
    .en(tmr_en), .tick(tick), .load(tmr_load), .expire(expire)
  );

  bw_fsm #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .fetch_vld(fetch_vld),
    .fetch_data(fetch_data), .expire(expire), .tmr_en(tmr_en),
    .tmr_load(tmr_load), .set_vec(set_vec), .bus_rst(bus_rst)
  );

  bw_status u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(clr_we),
    .clr_mask(clr_mask), .status(status)
  );

  bw_evt u_evt (
    .clk(clk), .rst(rst), .fire(set_vec != '0), .evt_sel(evt_sel),
    .evt_out(evt_out)
  );

  // run length of the bus reset pulse, kept for the checks below
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !bus_rst) begin
      run_q <= '0;
    end else if (run_q != RUN_W'(HOLD_CYC + 1)) begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  AST_RST_CLEAN: assert property (@(posedge clk)
    rst |=> (!bus_rst && status == '0 && evt_out == '0)); // R1

  AST_BUS_RST_MAX: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> (run_q < RUN_W'(HOLD_CYC))); // R4

  AST_BUS_RST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rst) |-> (run_q == RUN_W'(HOLD_CYC))); // R4

  AST_LOCK_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst) |-> status[STS_LOCK]); // R4

  AST_EVT_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (evt_out != '0) |-> (status != '0)); // R8

  AST_BLANK_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(status[STS_BLANK]) |-> ($past(fetch_vld) && $past(fetch_data) == {DATA_W{1'b1}})); // R6
endmodule

// File: tb/boot_watch_tb.sv
module boot_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst, cpu_rst, tick, fetch_vld, reload_we, clr_we;
  logic [7:0]  fetch_data;
  logic [15:0] reload_val;
  logic [2:0]  clr_mask, evt_sel;
  logic        bus_rst;
  logic [2:0]  status;
  logic [4:0]  evt_out;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_watch u_dut (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .tick(tick),
    .fetch_vld(fetch_vld), .fetch_data(fetch_data), .reload_we(reload_we),
    .reload_val(reload_val), .clr_we(clr_we), .clr_mask(clr_mask),
    .evt_sel(evt_sel), .bus_rst(bus_rst), .status(status), .evt_out(evt_out)
  );

  // behavioural reference: 0 idle, 1 waiting, 2 pulsing, 3 fetched
  int m_mode, m_cnt, m_hold, m_load;
  bit m_seen;
  int m_sts, m_evt;

  always @(posedge clk) begin
    int setm;
    started <= 1'b1;
    cycles++;
    setm = 0;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_hold = 0; m_load = 1000; m_seen = 0;
      m_sts = 0; m_evt = 0;
    end else begin
      if (m_mode == 0) begin
        if (!cpu_rst) begin m_mode = 1; m_cnt = m_load; m_seen = 0; end
      end else if (m_mode == 1) begin
        if (cpu_rst) begin m_mode = 0; m_seen = 0; end
        else if (fetch_vld) begin
          m_mode = 3;
          if (fetch_data == 8'hFF) setm = setm | 4;
        end else if (tick) begin
          if (m_cnt == 0) begin
            if (!m_seen) begin m_seen = 1; m_cnt = m_load; setm = setm | 1; end
            else begin m_mode = 2; m_hold = 0; setm = setm | 2; end
          end else m_cnt = m_cnt - 1;
        end
      end else if (m_mode == 2) begin
        if (m_hold == HOLD - 1) begin m_mode = 0; m_seen = 0; end
        else m_hold = m_hold + 1;
      end else begin
        if (cpu_rst) m_mode = 0;
      end
      if (reload_we) m_load = reload_val;
      if (clr_we) m_sts = m_sts & ~int'(clr_mask);
      m_sts = m_sts | setm;
      m_evt = (setm != 0 && evt_sel < 5) ? (1 << evt_sel) : 0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_chk++;
      if (bus_rst !== (m_mode == 2)) begin
        n_fail++;
        $display("FAIL R4 model bus_rst act=%0b exp=%0b t=%0t", bus_rst, (m_mode == 2), $time);
      end
      n_chk++;
      if (status !== m_sts[2:0]) begin
        n_fail++;
        $display("FAIL R7 model status act=%b exp=%b t=%0t", status, m_sts[2:0], $time);
      end
      n_chk++;
      if (evt_out !== m_evt[4:0]) begin
        n_fail++;
        $display("FAIL R8 model evt_out act=%b exp=%b t=%0t", evt_out, m_evt[4:0], $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = 3'b111;
    cyc(1);
    clr_we = 1'b0; clr_mask = 3'b000;
  endtask

  initial begin
    rst = 1'b1; cpu_rst = 1'b1; tick = 1'b0; fetch_vld = 1'b0; fetch_data = 8'h00;
    reload_we = 1'b0; reload_val = 16'd0; clr_we = 1'b0; clr_mask = 3'b000; evt_sel = 3'd0;
    cyc(3);
    rst = 1'b0;
    chk("R1 bus_rst after reset", bus_rst, 0);
    chk("R1 status after reset", status, 0);
    chk("R1 evt_out after reset", evt_out, 0);

    // R9: small load value, then blank first fetch
    reload_we = 1'b1; reload_val = 16'd3;
    cyc(1);
    reload_we = 1'b0;
    cpu_rst = 1'b0; tick = 1'b1;
    cyc(2);
    fetch_vld = 1'b1; fetch_data = 8'hFF;
    cyc(1);
    fetch_vld = 1'b0;
    chk("R6 blank first fetch", status, 3'b100);
    chk("R8 event line SMI", evt_out, 5'b00001);
    cyc(1);
    chk("R8 one-cycle pulse", evt_out, 0);
    cyc(20);
    chk("R5 no timeout after fetch", status, 3'b100);
    chk("R5 no bus reset after fetch", bus_rst, 0);
    clr_we = 1'b1; clr_mask = 3'b100;
    cyc(1);
    clr_we = 1'b0;
    chk("R7 clear blank bit", status, 0);
    fetch_vld = 1'b1; fetch_data = 8'hFF;
    cyc(1);
    fetch_vld = 1'b0;
    chk("R6 later fetch not inspected", status, 0);

    // R3 R4: hang with NMI routing
    cpu_rst = 1'b1; evt_sel = 3'd3;
    cyc(2);
    cpu_rst = 1'b0;
    cyc(4);
    chk("R2 no expiry before tick L+1", status, 0);
    cyc(1);
    chk("R3 first timeout bit", status, 3'b001);
    chk("R8 event line NMI", evt_out, 5'b01000);
    chk("R3 no bus reset on first expiry", bus_rst, 0);
    cyc(3);
    chk("R4 no bus reset before second expiry", bus_rst, 0);
    cyc(1);
    chk("R4 bus reset on second expiry", bus_rst, 1);
    chk("R4 lockup bit", status, 3'b011);
    begin
      int n;
      n = 0;
      while (bus_rst && n < 100) begin n++; cyc(1); end
      chk("R4 bus reset length", n, HOLD);
    end
    // R10: re-arm after the pulse with cpu_rst low
    clear_all();
    cyc(3);
    chk("R10 rearm after pulse, pre-expiry", status, 0);
    cyc(1);
    chk("R10 rearm after pulse, first timeout", status, 3'b001);
    fetch_vld = 1'b1; fetch_data = 8'h00;
    cyc(1);
    fetch_vld = 1'b0;
    cyc(10);
    chk("R6 non-blank data leaves flag clear", status, 3'b001);
    chk("R5 fetch after first expiry stops lockup", bus_rst, 0);

    // R10: cancel while armed forgets the first expiry
    cpu_rst = 1'b1; clr_we = 1'b1; clr_mask = 3'b111;
    cyc(2);
    clr_we = 1'b0; cpu_rst = 1'b0;
    cyc(5);
    chk("R3 first timeout again", status, 3'b001);
    cpu_rst = 1'b1;
    cyc(1);
    cpu_rst = 1'b0;
    cyc(8);
    chk("R10 no lockup after cancel", status, 3'b001);
    chk("R10 no bus reset after cancel", bus_rst, 0);
    cyc(1);
    chk("R10 lockup after two fresh expiries", bus_rst, 1);
    cpu_rst = 1'b1;
    cyc(HOLD + 2);
    chk("R10 idle after pulse while cpu_rst high", bus_rst, 0);

    // R8: reserved selector code
    clear_all();
    evt_sel = 3'd6; cpu_rst = 1'b0;
    cyc(5);
    chk("R8 code 6 status still set", status, 3'b001);
    chk("R8 code 6 gives no pulse", evt_out, 0);

    // R5: fetch in the same cycle as an expiry
    cpu_rst = 1'b1; evt_sel = 3'd1;
    clear_all();
    cyc(1);
    cpu_rst = 1'b0;
    cyc(4);
    fetch_vld = 1'b1; fetch_data = 8'h12;
    cyc(1);
    fetch_vld = 1'b0;
    chk("R5 fetch beats expiry", status, 0);
    cyc(10);
    chk("R5 stays clear", status, 0);

    // R7: set and clear in the same cycle
    cpu_rst = 1'b1;
    cyc(2);
    cpu_rst = 1'b0;
    cyc(4);
    clr_we = 1'b1; clr_mask = 3'b001;
    cyc(1);
    clr_we = 1'b0;
    chk("R7 set wins over clear", status, 3'b001);

    // R9: reload during a running count
    cpu_rst = 1'b1;
    clear_all();
    cyc(1);
    cpu_rst = 1'b0;
    cyc(2);
    reload_we = 1'b1; reload_val = 16'd10;
    cyc(1);
    reload_we = 1'b0;
    cyc(2);
    chk("R9 running count unchanged", status, 3'b001);
    cyc(10);
    chk("R9 new value used at reload", bus_rst, 0);
    cyc(1);
    chk("R9 second expiry after L+1 new ticks", bus_rst, 1);
    cpu_rst = 1'b1;
    cyc(HOLD + 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule